// File: doc/BRIEF.md
# PLL Lock Clock Supervisor

This block watches the lock indicator of a clock synthesizer and decides how the system clock is produced. It gates the synthesizer output clock, chooses between that clock and a backup clock, and can turn a loss of lock into a hard reset. It also raises a maskable interrupt on every change of the lock state. The clock multiplexer itself lives elsewhere; this block only drives its enable and select.

Software controls it through one configuration word holding four bits: a request to run from the backup clock, a backup-clock permission, an escalate-on-unlock enable and an interrupt mask. While a hard reset is in progress the hardware owns the backup request. It holds the request high while the synthesizer is unlocked and drops it once lock returns. A power-on reset starts a hard reset of fixed length, so the chip comes up on the backup clock until lock is seen.

Top module: `lock_supervisor`

## Requirements
- R1: While `por_n` is low: `pll_clk_en`=0, `lock_pend`=0, `hreset_out`=1 and `cfg_rdata`=4'b0011. After `por_n` rises, `hreset_out` stays high for 4 more clock edges, unless it is retriggered.
- R2: `lock_status` equals the value `lock_raw` had two rising edges earlier.
- R3: After power-on, `pll_clk_en` stays 0 until `lock_status` has been 1. It becomes 1 one edge after `lock_status` is 1.
- R4: With the escalate bit (`cfg_rdata[2]`) at 0, a 1-to-0 change of `lock_status` outside hard reset raises no hard reset and leaves `pll_clk_en` unchanged.
- R5: A 1-to-0 change of `lock_status` while the escalate bit is 1, or a high `hreset_req`, makes `hreset_out` high for exactly 4 cycles starting at the next edge. A new trigger restarts the count.
- R6: A 1-to-0 change of `lock_status` that triggers a hard reset clears `pll_clk_en` at the next edge. Any edge taken while `hreset_out` is high and `lock_status` is 0 also clears it. It stays 0 until the edge after `lock_status` is 1.
- R7: At every edge taken while `hreset_out` is high, the backup request bit (`cfg_rdata[0]`) is loaded with the inverse of `lock_status`.
- R8: `backup_sel` is 1 exactly when the backup request bit and the permission bit (`cfg_rdata[1]`) are both 1. With the permission bit at 0 it is never 1.
- R9: Outside hard reset, a cycle with `cfg_we`=1 loads `cfg_wdata` into the configuration: bit 0 backup request, bit 1 backup permission, bit 2 escalate on unlock, bit 3 interrupt mask. The new value is readable on `cfg_rdata` after the edge.
- R10: While `hreset_out` is high, `cfg_we` has no effect on bits 3..1, and bit 0 follows R7 only.
- R11: Every change of `lock_status` in either direction sets `lock_pend` at the following edge. `lock_irq` equals `lock_pend` AND the mask bit.
- R12: `irq_clr`=1 clears `lock_pend` at the next edge, except that a lock change detected in the same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| lock_raw | input | 1 | Asynchronous lock indicator from the synthesizer |
| hreset_req | input | 1 | External hard-reset request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration write data |
| irq_clr | input | 1 | Write-one-to-clear for the lock-change flag |
| cfg_rdata | output | 4 | Current configuration word |
| lock_status | output | 1 | Synchronized lock indicator |
| pll_clk_en | output | 1 | Enable for the synthesizer output clock |
| backup_sel | output | 1 | Select for the backup clock in the external mux |
| hreset_out | output | 1 | Hard-reset request, held 4 cycles |
| lock_pend | output | 1 | Sticky lock-change flag |
| lock_irq | output | 1 | Masked lock-change interrupt |

## Verification
The bench toggles the lock input during a hard reset. A design that forced the backup request only once, or wrote it only on entry, would leave a stale bit after lock came back, and the wrong clock would be selected. It drops lock with escalation both off and on. A design that gated the clock in the tolerant case would stall a running chip, and one that kept it enabled in the escalating case would run from an unlocked clock. It retriggers hard reset before the count expires, tries configuration writes during reset, and makes a lock change land in the same cycle as a flag clear. These catch stretch counters that do not restart, writes that leak through the reset, and a clear that swallows a new event.

// File: rtl/lksup_pkg.sv
package lksup_pkg;

  typedef struct packed {
    logic irq_mask;
    logic lolre;
    logic limp_en;
    logic to_backup;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{irq_mask: 1'b0, lolre: 1'b0, limp_en: 1'b1, to_backup: 1'b1};

  // Next value of the backup request bit.
  function automatic logic backup_req_next(input logic in_hrst, input logic locked,
                                           input logic wr, input logic wbit, input logic cur);
    if (in_hrst)  return ~locked;
    else if (wr)  return wbit;
    else          return cur;
  endfunction

  // Sticky flag with set priority over clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/lksup_sync.sv
module lksup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic async_in,
  output logic sync_out,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= async_in;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) prev <= 1'b0;
    else        prev <= chain[LAST];
  end

  assign sync_out = chain[LAST];
  assign rise     = chain[LAST] & ~prev;
  assign fall     = ~chain[LAST] & prev;
endmodule

// File: rtl/lksup_rstgen.sv
module lksup_rstgen #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic trigger,
  output logic active
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           remain <= CW'(HOLD);
    else if (trigger)     remain <= CW'(HOLD);
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign active = (remain != 0);
endmodule

// File: rtl/lksup_ctrl.sv
module lksup_ctrl
  import lksup_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic locked,
  input  logic lock_rise,
  input  logic lock_fall,
  input  logic in_hrst,
  input  logic wr,
  input  cfg_t wdata,
  input  logic flag_clr,
  output cfg_t cfg,
  output logic escalate,
  output logic clk_en,
  output logic sel_backup,
  output logic pend,
  output logic irq
);
  logic lock_change;

  assign lock_change = lock_rise | lock_fall;
  assign escalate    = lock_fall & cfg.lolre;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg <= CFG_RESET;
    end else begin
      cfg.to_backup <= backup_req_next(in_hrst, locked, wr, wdata.to_backup, cfg.to_backup);
      if (wr && !in_hrst) begin
        cfg.limp_en  <= wdata.limp_en;
        cfg.lolre    <= wdata.lolre;
        cfg.irq_mask <= wdata.irq_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                    clk_en <= 1'b0;
    else if (locked)               clk_en <= 1'b1;
    else if (in_hrst || escalate)  clk_en <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) pend <= 1'b0;
    else        pend <= sticky_next(pend, lock_change, flag_clr);
  end

  assign sel_backup = cfg.to_backup & cfg.limp_en;
  assign irq        = pend & cfg.irq_mask;
endmodule

// File: rtl/lock_supervisor.sv
module lock_supervisor
  import lksup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HRST_HOLD   = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       lock_raw,
  input  logic       hreset_req,
  input  logic       cfg_we,
  input  logic [3:0] cfg_wdata,
  input  logic       irq_clr,
  output logic [3:0] cfg_rdata,
  output logic       lock_status,
  output logic       pll_clk_en,
  output logic       backup_sel,
  output logic       hreset_out,
  output logic       lock_pend,
  output logic       lock_irq
);
  logic lock_rise_ev;
  logic lock_fall_ev;
  logic escalate_ev;
  logic hrst_trigger;
  cfg_t cfg_q;

  lksup_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .por_n    (por_n),
    .async_in (lock_raw),
    .sync_out (lock_status),
    .rise     (lock_rise_ev),
    .fall     (lock_fall_ev)
  );

  assign hrst_trigger = hreset_req | escalate_ev;

  lksup_rstgen #(.HOLD(HRST_HOLD)) u_rst (
    .clk     (clk),
    .por_n   (por_n),
    .trigger (hrst_trigger),
    .active  (hreset_out)
  );

  lksup_ctrl u_ctrl (
    .clk        (clk),
    .por_n      (por_n),
    .locked     (lock_status),
    .lock_rise  (lock_rise_ev),
    .lock_fall  (lock_fall_ev),
    .in_hrst    (hreset_out),
    .wr         (cfg_we),
    .wdata      (cfg_t'(cfg_wdata)),
    .flag_clr   (irq_clr),
    .cfg        (cfg_q),
    .escalate   (escalate_ev),
    .clk_en     (pll_clk_en),
    .sel_backup (backup_sel),
    .pend       (lock_pend),
    .irq        (lock_irq)
  );

  assign cfg_rdata = cfg_q;
endmodule

// File: rtl/lock_supervisor_chk.sv
module lock_supervisor_chk (
  input logic       clk,
  input logic       por_n,
  input logic       lock_status,
  input logic       lock_rise_ev,
  input logic       lock_fall_ev,
  input logic       escalate_ev,
  input logic       hreset_out,
  input logic       pll_clk_en,
  input logic       lock_pend,
  input logic       lock_irq,
  input logic [3:0] cfg_rdata
);
  logic seen_lock;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           seen_lock <= 1'b0;
    else if (lock_status) seen_lock <= 1'b1;
  end

  assert_no_clock_before_lock_R3: assert property (@(posedge clk) disable iff (!por_n)
    !seen_lock |-> !pll_clk_en);

  assert_tolerate_unlock_R4: assert property (@(posedge clk) disable iff (!por_n)
    (lock_fall_ev && !cfg_rdata[2] && !hreset_out) |=> (pll_clk_en == $past(pll_clk_en)));

  assert_escalate_reset_R5: assert property (@(posedge clk) disable iff (!por_n)
    escalate_ev |=> hreset_out);

  assert_escalate_gates_clock_R6: assert property (@(posedge clk) disable iff (!por_n)
    escalate_ev |=> !pll_clk_en);

  assert_force_backup_R7: assert property (@(posedge clk) disable iff (!por_n)
    (hreset_out && !lock_status) |=> cfg_rdata[0]);

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!por_n)
    hreset_out |=> $stable(cfg_rdata[3:1]));

  assert_change_sets_flag_R11: assert property (@(posedge clk) disable iff (!por_n)
    (lock_rise_ev || lock_fall_ev) |=> lock_pend);

  assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!por_n)
    lock_irq |-> lock_pend);
endmodule

bind lock_supervisor lock_supervisor_chk u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .lock_status  (lock_status),
  .lock_rise_ev (lock_rise_ev),
  .lock_fall_ev (lock_fall_ev),
  .escalate_ev  (escalate_ev),
  .hreset_out   (hreset_out),
  .pll_clk_en   (pll_clk_en),
  .lock_pend    (lock_pend),
  .lock_irq     (lock_irq),
  .cfg_rdata    (cfg_rdata)
);

// File: tb/tb_lock_supervisor.sv
module tb_lock_supervisor;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       lock_raw = 1'b0;
  logic       hreset_req = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = 4'h0;
  logic       irq_clr = 1'b0;
  logic [3:0] cfg_rdata;
  logic       lock_status, pll_clk_en, backup_sel, hreset_out, lock_pend, lock_irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lock_supervisor dut (
    .clk(clk), .por_n(por_n), .lock_raw(lock_raw), .hreset_req(hreset_req),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .irq_clr(irq_clr),
    .cfg_rdata(cfg_rdata), .lock_status(lock_status), .pll_clk_en(pll_clk_en),
    .backup_sel(backup_sel), .hreset_out(hreset_out), .lock_pend(lock_pend),
    .lock_irq(lock_irq)
  );

  // Reference state, kept as histories and counts rather than mirrored registers.
  logic [1:0] hist;      // hist[0] newest sample of lock_raw, hist[1] = lock_status
  logic       last_stat; // lock_status one edge ago
  int         rst_left;  // hard-reset cycles remaining
  bit         gate_on;
  logic [3:0] m_cfg;
  bit         m_flag;

  function automatic bit sel_of(input logic [3:0] c);
    return (c[0] == 1'b1) && (c[1] == 1'b1);
  endfunction

  task automatic model_reset();
    hist = 2'b00; last_stat = 1'b0; rst_left = 4; gate_on = 0;
    m_cfg = 4'b0011; m_flag = 0;
  endtask

  task automatic model_step(input logic lk, input logic hq, input logic we,
                            input logic [3:0] wd, input logic clr);
    bit changed, dropped, esc, busy;
    logic [3:0] nc;
    changed = (hist[1] != last_stat);
    dropped = changed && !hist[1];
    esc     = dropped && m_cfg[2];
    busy    = rst_left > 0;
    nc = m_cfg;
    if (busy) nc[0] = !hist[1];
    else if (we) nc = wd;
    if (hist[1]) gate_on = 1;
    else if (busy || esc) gate_on = 0;
    if (hq || esc) rst_left = 4;
    else if (rst_left > 0) rst_left--;
    m_flag = changed ? 1 : (clr ? 0 : m_flag);
    m_cfg = nc;
    last_stat = hist[1];
    hist = {hist[0], lk};
  endtask

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 lock_status", {3'b0, lock_status}, {3'b0, hist[1]});
    check("R3/R4/R6 pll_clk_en", {3'b0, pll_clk_en}, {3'b0, gate_on});
    check("R1/R5 hreset_out", {3'b0, hreset_out}, {3'b0, rst_left > 0});
    check("R8 backup_sel", {3'b0, backup_sel}, {3'b0, sel_of(m_cfg)});
    check("R7/R9/R10 cfg_rdata", cfg_rdata, m_cfg);
    check("R11/R12 lock_pend", {3'b0, lock_pend}, {3'b0, m_flag});
    check("R11 lock_irq", {3'b0, lock_irq}, {3'b0, m_flag & m_cfg[3]});
  endtask

  task automatic cyc(input logic lk, input logic hq, input logic we,
                     input logic [3:0] wd, input logic clr);
    lock_raw = lk; hreset_req = hq; cfg_we = we; cfg_wdata = wd; irq_clr = clr;
    model_step(lk, hq, we, wd, clr);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input logic lk, input int n);
    for (int i = 0; i < n; i++) cyc(lk, 1'b0, 1'b0, 4'h0, 1'b0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    int seed;
    logic lk;
    seed = 32'h5EED_0A17;
    void'($urandom(seed));
    model_reset();
    // R1: state during power-on reset
    repeat (3) begin
      @(negedge clk);
      compare_all();
      check("R1 reset cfg", cfg_rdata, 4'b0011);
    end
    por_n = 1'b1;
    // R1: hard reset holds for 4 edges after release; R3: no clock before lock
    idle(1'b0, 3);
    check("R1 hreset still high", {3'b0, hreset_out}, 4'h1);
    idle(1'b0, 1);
    check("R1 hreset done", {3'b0, hreset_out}, 4'h0);
    check("R3 no clock yet", {3'b0, pll_clk_en}, 4'h0);
    // R9: write outside reset with permission off -> no backup (R8)
    cyc(1'b0, 1'b0, 1'b1, 4'b1001, 1'b0);
    check("R8 permission off", {3'b0, backup_sel}, 4'h0);
    // R2/R3: lock arrives
    idle(1'b1, 3);
    check("R3 clock enabled", {3'b0, pll_clk_en}, 4'h1);
    check("R11 irq on lock rise", {3'b0, lock_irq}, 4'h1);
    // R12: clear
    cyc(1'b1, 1'b0, 1'b0, 4'h0, 1'b1);
    check("R12 cleared", {3'b0, lock_pend}, 4'h0);
    // R4: tolerated unlock with escalate off
    idle(1'b0, 4);
    check("R4 no reset", {3'b0, hreset_out}, 4'h0);
    check("R4 clock kept", {3'b0, pll_clk_en}, 4'h1);
    // R12: lock change coincides with clear -> flag stays
    idle(1'b1, 2);
    cyc(1'b1, 1'b0, 1'b0, 4'h0, 1'b1);
    check("R12 set wins", {3'b0, lock_pend}, 4'h1);
    // R5/R6: escalate on unlock
    cyc(1'b1, 1'b0, 1'b1, 4'b0110, 1'b0);
    idle(1'b0, 3);
    check("R5 escalated", {3'b0, hreset_out}, 4'h1);
    check("R6 clock gated", {3'b0, pll_clk_en}, 4'h0);
    // R10: write during reset ignored; R7: lock toggling during reset
    cyc(1'b1, 1'b0, 1'b1, 4'b1000, 1'b0);
    for (int i = 0; i < 6; i++) cyc(i[0], (i == 2), 1'b0, 4'h0, 1'b0);
    idle(1'b1, 8);
    check("R7 request dropped after lock", {3'b0, cfg_rdata[0]}, 4'h0);
    // R5: retrigger restarts count
    cyc(1'b1, 1'b1, 1'b0, 4'h0, 1'b0);
    idle(1'b1, 2);
    cyc(1'b1, 1'b1, 1'b0, 4'h0, 1'b0);
    idle(1'b1, 3);
    check("R5 retrigger", {3'b0, hreset_out}, 4'h1);
    idle(1'b1, 2);
    // Constrained random
    lk = 1'b1;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 11) == 0) lk = ~lk;
      cyc(lk, ($urandom_range(0, 120) == 0), ($urandom_range(0, 7) == 0),
          4'($urandom_range(0, 15)), ($urandom_range(0, 5) == 0));
    end
    summary();
  end
endmodule